// File: doc/BRIEF.md
# STS-3c Receive Frame Aligner

This block sits behind clock recovery on a 155.52 Mbit/s receive line. It takes one retimed NRZ bit per recovered-clock cycle and finds the unscrambled STS-3c framing word: three bytes of F6h followed by three bytes of 28h. The word can start at any bit offset in the stream. The block compares a 48-bit sliding window of the raw bits against that word on every cycle.

After the first match the block fixes byte alignment. A frame-position counter then predicts where the next framing word must end, one frame length later. A three-state tracker (hunt, pre-sync, sync) confirms the alignment and declares loss of frame when the word goes missing. While alignment is known the block presents aligned bytes with a strobe, and it marks the first framing byte of each frame while in sync.

A separate sticky interrupt register has one bit for loss of the optical signal and one bit for loss of frame. Each bit is cleared by a write-one strobe. An active-low interrupt line is asserted while any bit of that register is set.

Top module: `sts_frm_aligner`

## Requirements
- R1: The framing word is the 48 raw bits F6F6F6282828h, with the first received bit taken as the MSB of the first F6h byte. It is recognised at every bit offset of the input stream.
- R2: In hunt, a match moves the block to pre-sync and fixes byte alignment. After CONFIRM_HITS further matches at the predicted positions, each FRAME_BYTES*8 bits apart, the block enters sync. `in_frame` goes high on the clock edge after the one that samples the final bit of the last confirming word.
- R3: In pre-sync, if the word is absent at the predicted position, the block returns to hunt. It then needs a fresh match plus CONFIRM_HITS confirmations before it reaches sync again.
- R4: In sync, LOSS_MISSES consecutive missing words return the block to hunt. On the edge after the sampling edge of the last missing word's final bit, `in_frame` falls and `lof_pulse` is high for exactly one cycle. A word found at its position resets the miss count.
- R5: Outside hunt, `byte_stb` pulses for one cycle every 8 cycles. With each pulse `data_out` shows the 8 most recently received bits (first received bit in bit 7), aligned to the framing word. The update comes one edge after the byte's last bit is sampled. In hunt no strobe is produced.
- R6: In sync, `sof` is high for exactly 8 cycles, together with `data_out` holding the first F6h byte of each frame. `sof` is never high outside sync.
- R7: A high `los_in` sampled on an edge sets `irq_stat[0]` at that edge. `irq_n` is low whenever any bit of `irq_stat` is set, and high otherwise.
- R8: A loss-of-frame declaration sets `irq_stat[1]` on the same edge as `lof_pulse`.
- R9: Each `irq_stat` bit holds until a cycle with the matching `irq_clr` bit high. When set and clear occur together, set wins. A clear bit has no effect on the other interrupt bit.
- R10: After reset, the block is in hunt, all outputs are zero, and `irq_n` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Recovered bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_bit | input | 1 | Retimed serial receive bit |
| los_in | input | 1 | Loss of optical signal from the optics |
| irq_clr | input | 2 | Write-one-to-clear strobes for irq_stat |
| data_out | output | 8 | Aligned receive byte |
| byte_stb | output | 1 | One-cycle strobe when data_out updates |
| sof | output | 1 | First framing byte marker (sync only) |
| in_frame | output | 1 | Block is in sync |
| lof_pulse | output | 1 | One-cycle loss-of-frame event |
| irq_stat | output | 2 | Sticky interrupt bits: [0] optical loss, [1] loss of frame |
| irq_n | output | 1 | Active-low interrupt |

## Verification
Each bit is driven on a falling edge and numbered. Results are read on the next falling edge, so an output read after bit k reflects the rising edge that sampled bit k. Lock, loss and sof changes all register on the edge after the bit that decides them, so the bench expects each of them one bit index after that bit. For a word ending at index e, lock shows at e+1. For a first F6h byte ending at e, sof and the byte show at e+1. Interrupt bits show right after the bit index on which `los_in` or the clear strobe was driven. Lock and sof indices are computed from the bit offset and the frame length for every offset 0..7. Every strobed byte is compared against the byte expected at its stream position.

// File: rtl/sts_frm_pkg.sv
package sts_frm_pkg;
  localparam int unsigned PAT_W = 48;
  localparam logic [7:0] SYNC_BYTE_A = 8'hF6;
  localparam logic [7:0] SYNC_BYTE_B = 8'h28;

  typedef enum logic [1:0] {ST_HUNT, ST_PRESYNC, ST_SYNC} frm_state_e;

  // Framing word, first received bit in the MSB
  function automatic logic [PAT_W-1:0] frame_word();
    return {SYNC_BYTE_A, SYNC_BYTE_A, SYNC_BYTE_A,
            SYNC_BYTE_B, SYNC_BYTE_B, SYNC_BYTE_B};
  endfunction

  // Position counter step with wrap at the frame length
  function automatic int unsigned wrap_next(int unsigned cur, int unsigned limit);
    return (cur == limit - 1) ? 0 : cur + 1;
  endfunction

  // Bit position within a frame at which the first framing byte completes
  function automatic int unsigned first_byte_pos(int unsigned frame_bits);
    return frame_bits - (PAT_W - 8);
  endfunction
endpackage

// File: rtl/sts_frm_shift.sv
module sts_frm_shift
  import sts_frm_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_in,
  output logic [PAT_W-1:0] window,
  output logic             hit
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) window <= '0;
    else        window <= {window[PAT_W-2:0], bit_in};
  end

  assign hit = (window == frame_word());
endmodule

// File: rtl/sts_frm_track.sv
module sts_frm_track
  import sts_frm_pkg::*;
#(
  parameter int unsigned FRAME_BITS   = 19440,
  parameter int unsigned CONFIRM_HITS = 2,
  parameter int unsigned LOSS_MISSES  = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       hit,
  output frm_state_e state,
  output logic       slot_hit,
  output logic       lof_evt,
  output logic       byte_edge,
  output logic       sof_edge
);
  localparam int unsigned CW  = $clog2(FRAME_BITS);
  localparam int unsigned CFW = $clog2(CONFIRM_HITS + 1);
  localparam int unsigned MSW = $clog2(LOSS_MISSES + 1);
  localparam int unsigned SOF_POS = first_byte_pos(FRAME_BITS);

  frm_state_e     st_d;
  logic [CW-1:0]  pos_q, pos_d;
  logic [CFW-1:0] conf_q, conf_d;
  logic [MSW-1:0] miss_q, miss_d;
  logic           at_slot;

  assign at_slot   = (pos_q == '0);
  assign slot_hit  = hit && at_slot && (state != ST_HUNT);
  assign byte_edge = (state != ST_HUNT) && (pos_q[2:0] == 3'd0);
  assign sof_edge  = (state == ST_SYNC) && (pos_q == CW'(SOF_POS));

  always_comb begin
    st_d    = state;
    pos_d   = CW'(wrap_next(32'(pos_q), FRAME_BITS));
    conf_d  = conf_q;
    miss_d  = miss_q;
    lof_evt = 1'b0;
    unique case (state)
      ST_HUNT: begin
        pos_d = '0;
        if (hit) begin
          st_d   = ST_PRESYNC;
          pos_d  = CW'(1);
          conf_d = '0;
        end
      end
      ST_PRESYNC: begin
        if (at_slot) begin
          if (!hit) begin
            st_d = ST_HUNT;
          end else if (conf_q == CFW'(CONFIRM_HITS - 1)) begin
            st_d   = ST_SYNC;
            miss_d = '0;
          end else begin
            conf_d = conf_q + 1'b1;
          end
        end
      end
      ST_SYNC: begin
        if (at_slot) begin
          if (hit) begin
            miss_d = '0;
          end else if (miss_q == MSW'(LOSS_MISSES - 1)) begin
            st_d    = ST_HUNT;
            lof_evt = 1'b1;
          end else begin
            miss_d = miss_q + 1'b1;
          end
        end
      end
      default: st_d = ST_HUNT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_HUNT;
      pos_q  <= '0;
      conf_q <= '0;
      miss_q <= '0;
    end else begin
      state  <= st_d;
      pos_q  <= pos_d;
      conf_q <= conf_d;
      miss_q <= miss_d;
    end
  end
endmodule

// File: rtl/sts_frm_irq.sv
module sts_frm_irq #(
  parameter int unsigned NBITS = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NBITS-1:0] set,
  input  logic [NBITS-1:0] clr,
  output logic [NBITS-1:0] stat,
  output logic             irq_n
);
  // Set has priority over clear in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat <= '0;
    else        stat <= set | (stat & ~clr);
  end

  assign irq_n = ~(|stat);
endmodule

// File: rtl/sts_frm_aligner.sv
module sts_frm_aligner
  import sts_frm_pkg::*;
#(
  parameter int unsigned FRAME_BYTES  = 2430,
  parameter int unsigned CONFIRM_HITS = 2,
  parameter int unsigned LOSS_MISSES  = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_bit,
  input  logic       los_in,
  input  logic [1:0] irq_clr,
  output logic [7:0] data_out,
  output logic       byte_stb,
  output logic       sof,
  output logic       in_frame,
  output logic       lof_pulse,
  output logic [1:0] irq_stat,
  output logic       irq_n
);
  localparam int unsigned FRAME_BITS = FRAME_BYTES * 8;

  logic [PAT_W-1:0] window;
  logic             hit_w;
  frm_state_e       state;
  logic             slot_hit_w;
  logic             lof_evt_w;
  logic             byte_edge_w;
  logic             sof_edge_w;
  logic             hunt_w;

  sts_frm_shift u_shift (
    .clk    (clk),
    .rst_n  (rst_n),
    .bit_in (rx_bit),
    .window (window),
    .hit    (hit_w)
  );

  sts_frm_track #(
    .FRAME_BITS   (FRAME_BITS),
    .CONFIRM_HITS (CONFIRM_HITS),
    .LOSS_MISSES  (LOSS_MISSES)
  ) u_track (
    .clk       (clk),
    .rst_n     (rst_n),
    .hit       (hit_w),
    .state     (state),
    .slot_hit  (slot_hit_w),
    .lof_evt   (lof_evt_w),
    .byte_edge (byte_edge_w),
    .sof_edge  (sof_edge_w)
  );

  sts_frm_irq #(.NBITS(2)) u_irq (
    .clk   (clk),
    .rst_n (rst_n),
    .set   ({lof_evt_w, los_in}),
    .clr   (irq_clr),
    .stat  (irq_stat),
    .irq_n (irq_n)
  );

  assign hunt_w   = (state == ST_HUNT);
  assign in_frame = (state == ST_SYNC);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_out  <= '0;
      byte_stb  <= 1'b0;
      sof       <= 1'b0;
      lof_pulse <= 1'b0;
    end else begin
      byte_stb  <= byte_edge_w;
      lof_pulse <= lof_evt_w;
      if (byte_edge_w) begin
        data_out <= window[7:0];
        sof      <= sof_edge_w;
      end
    end
  end
endmodule

// File: rtl/sts_frm_checker.sv
module sts_frm_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       los_in,
  input logic [1:0] irq_clr,
  input logic [1:0] irq_stat,
  input logic       irq_n,
  input logic       in_frame,
  input logic       sof,
  input logic       byte_stb,
  input logic       lof_pulse,
  input logic       hunt_w,
  input logic       slot_hit_w
);
  AST_SOF_IN_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
    sof |-> in_frame); // R6
  AST_STB_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    byte_stb |=> !byte_stb); // R5
  AST_NO_STB_HUNT: assert property (@(posedge clk) disable iff (!rst_n)
    hunt_w |=> !byte_stb); // R5
  AST_LOCK_ON_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_frame) |-> $past(slot_hit_w)); // R2
  AST_LOF_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    lof_pulse |-> (!in_frame && $past(in_frame))); // R4
  AST_LOS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    los_in |=> (irq_stat[0] && !irq_n)); // R7
  AST_LOF_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    lof_pulse |-> irq_stat[1]); // R8
  AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_stat[0] && !irq_clr[0]) |=> irq_stat[0]); // R9
endmodule

bind sts_frm_aligner sts_frm_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .los_in     (los_in),
  .irq_clr    (irq_clr),
  .irq_stat   (irq_stat),
  .irq_n      (irq_n),
  .in_frame   (in_frame),
  .sof        (sof),
  .byte_stb   (byte_stb),
  .lof_pulse  (lof_pulse),
  .hunt_w     (hunt_w),
  .slot_hit_w (slot_hit_w)
);

// File: tb/sts_frm_aligner_bench.sv
module sts_frm_aligner_bench;
  localparam int FBY = 16;
  localparam int FB  = FBY * 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_bit = 1'b0;
  logic los_in = 1'b0;
  logic [1:0] irq_clr = 2'b00;
  logic [7:0] data_out;
  logic byte_stb, sof, in_frame, lof_pulse, irq_n;
  logic [1:0] irq_stat;

  int nchk = 0, nerr = 0, idx = -1, base = 0;
  int rise_idx, fall_idx, sof_rise_idx, sof_hi, lof_idx, lof_cnt, stb_cnt;
  logic [7:0] sof_byte;
  logic prev_if, prev_sof, chk_bytes;

  always #2.5 clk = ~clk;

  sts_frm_aligner #(.FRAME_BYTES(FBY), .CONFIRM_HITS(2), .LOSS_MISSES(4)) u_sts_frm_aligner (
    .clk(clk), .rst_n(rst_n), .rx_bit(rx_bit), .los_in(los_in), .irq_clr(irq_clr),
    .data_out(data_out), .byte_stb(byte_stb), .sof(sof), .in_frame(in_frame),
    .lof_pulse(lof_pulse), .irq_stat(irq_stat), .irq_n(irq_n)
  );

  task automatic chk(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_byte(input int n);
    if (n < 3) return 8'hF6;
    if (n < 6) return 8'h28;
    return 8'(8'h40 + n);
  endfunction

  task automatic tick(input logic b);
    int rel;
    rx_bit = b;
    @(posedge clk);
    @(negedge clk);
    idx++;
    if (in_frame && !prev_if && rise_idx < 0) rise_idx = idx;
    if (!in_frame && prev_if && fall_idx < 0) fall_idx = idx;
    if (lof_pulse) begin lof_cnt++; if (lof_idx < 0) lof_idx = idx; end
    if (sof && !prev_sof && sof_rise_idx < 0) begin sof_rise_idx = idx; sof_byte = data_out; end
    if (sof) sof_hi++;
    if (byte_stb) stb_cnt++;
    if (chk_bytes && byte_stb) begin
      rel = idx - 1 - base;
      chk("R5 alignment", (rel + 1) % 8, 0);
      chk("R5 byte", int'(data_out), int'(exp_byte((rel / 8) % FBY)));
    end
    prev_if = in_frame;
    prev_sof = sof;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; rx_bit = 1'b0; los_in = 1'b0; irq_clr = 2'b00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idx = -1; rise_idx = -1; fall_idx = -1; sof_rise_idx = -1; sof_hi = 0;
    lof_idx = -1; lof_cnt = 0; stb_cnt = 0; prev_if = 1'b0; prev_sof = 1'b0;
    chk_bytes = 1'b0; base = 0;
  endtask

  task automatic send_frame(input logic bad);
    for (int i = 0; i < FBY; i++) begin
      logic [7:0] v;
      v = (bad && i == 0) ? 8'h00 : exp_byte(i);
      for (int b = 7; b >= 0; b--) tick(v[b]);
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    do_reset();
    // R10 reset state
    chk("R10 data_out", int'(data_out), 0);
    chk("R10 byte_stb", int'(byte_stb), 0);
    chk("R10 sof", int'(sof), 0);
    chk("R10 in_frame", int'(in_frame), 0);
    chk("R10 lof_pulse", int'(lof_pulse), 0);
    chk("R10 irq_stat", int'(irq_stat), 0);
    chk("R10 irq_n", int'(irq_n), 1);

    // R5: no strobe while hunting
    for (int k = 0; k < 200; k++) tick(1'b0);
    chk("R5 no strobe in hunt", stb_cnt, 0);

    // R1 R2 R6: sweep every bit offset
    for (int o = 0; o < 8; o++) begin
      do_reset();
      base = o;
      chk_bytes = 1'b1;
      for (int j = 0; j < o; j++) tick(1'(j & 1));
      for (int f = 0; f < 5; f++) send_frame(1'b0);
      chk("R1 R2 lock index", rise_idx, o + 2 * FB + 48);
      chk("R6 sof index", sof_rise_idx, o + 3 * FB + 8);
      chk("R6 sof byte", int'(sof_byte), 8'hF6);
      chk("R6 sof length", sof_hi, 16);
      chk("R4 no loss", lof_cnt, 0);
    end

    // R3: miss during pre-sync restarts the hunt
    do_reset();
    send_frame(1'b0);
    send_frame(1'b1);
    for (int f = 0; f < 3; f++) send_frame(1'b0);
    chk("R3 relock index", rise_idx, 4 * FB + 48);

    // R4: miss count cleared by a found word
    do_reset();
    for (int f = 0; f < 4; f++) send_frame(1'b0);
    for (int f = 0; f < 3; f++) send_frame(1'b1);
    send_frame(1'b0);
    for (int f = 0; f < 3; f++) send_frame(1'b1);
    send_frame(1'b0);
    chk("R4 held after three misses", int'(in_frame), 1);
    chk("R4 no loss", lof_cnt, 0);
    chk("R8 no loss bit", int'(irq_stat[1]), 0);

    // R4 R8: four consecutive misses
    do_reset();
    for (int f = 0; f < 4; f++) send_frame(1'b0);
    for (int f = 0; f < 4; f++) send_frame(1'b1);
    chk("R4 loss index", lof_idx, 7 * FB + 48);
    chk("R4 fall index", fall_idx, 7 * FB + 48);
    chk("R4 single pulse", lof_cnt, 1);
    chk("R8 loss bit", int'(irq_stat[1]), 1);
    chk("R7 irq_n on loss bit", int'(irq_n), 0);

    // R7 R9: optical loss interrupt
    do_reset();
    los_in = 1'b1; tick(1'b0); los_in = 1'b0;
    chk("R7 los bit", int'(irq_stat[0]), 1);
    chk("R7 irq_n", int'(irq_n), 0);
    for (int k = 0; k < 5; k++) tick(1'b0);
    chk("R9 sticky", int'(irq_stat[0]), 1);
    irq_clr = 2'b10; tick(1'b0); irq_clr = 2'b00;
    chk("R9 other clear ignored", int'(irq_stat[0]), 1);
    irq_clr = 2'b01; tick(1'b0); irq_clr = 2'b00;
    chk("R9 cleared", int'(irq_stat[0]), 0);
    chk("R7 irq_n released", int'(irq_n), 1);
    los_in = 1'b1; irq_clr = 2'b01; tick(1'b0); los_in = 1'b0; irq_clr = 2'b00;
    chk("R9 set wins", int'(irq_stat[0]), 1);

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule